// File: doc/BRIEF.md
# Video Output Field Buffer Handshake and Interrupt Controller

This block coordinates a video output DMA engine with the software that supplies its buffer pointers. The engine's event strobes arrive on input pins: buffer one drained, buffer two drained, horizontal blanking reached, field finished, and the active image area of the next field starting. The block turns those strobes into sticky status flags. Software clears a flag by writing a one to the matching acknowledge bit. Each flag has its own interrupt enable, and the interrupt line is the level OR of every enabled flag.

The field-threshold flag tells software that the pointers for the next field are needed. If that flag has not been acknowledged by the time the next field's active area begins, the block raises the underrun flag. In the same cycle it pulses an output that tells the engine to keep using its old pointers. The block also holds the engine's run enable and soft reset state. It checks the three-write start sequence and flags writes that break it. In message mode, the run enable clears itself when the message buffer drains.

Top module: `vout_hshk_irq`

## Requirements
- R1: After the asynchronous reset, `flags` is 0, `irq` is 0, and `run_en`, `soft_rst`, `seq_err` and `ptr_stale` are 0. The operating mode is video refresh and all interrupt enables are 0.
- R2: A strobe sets its sticky flag bit, which is visible from the cycle after the strobe. The bit positions are: 0 buffer-1 empty (`ev_buf1_empty`), 1 buffer-2 empty (`ev_buf2_empty`), 2 horizontal blank (`ev_hblank`), 3 underrun, 4 field threshold (`ev_field_end`).
- R3: An acknowledge write (`ack_we`=1) clears every flag whose `ack_bits` bit is 1, from the next cycle on. Zero bits leave their flags untouched.
- R4: When a strobe and an acknowledge of the same flag arrive in one cycle, the strobe wins and the flag stays set.
- R5: `ev_active_start` while the field-threshold flag is set, and not acknowledged in that same cycle, sets the underrun flag. In the same cycle the flag is set, `ptr_stale` pulses high for one cycle. If the acknowledge arrived earlier or in the same cycle, neither happens.
- R6: `irq` is high exactly when some flag is set whose bit in the last written `wr_irq_en` is 1. A disabled flag has no effect on `irq`.
- R7: A control write (`wr_en`) with `wr_rst`=1 and `wr_run`=0 enters soft reset: `soft_rst`=1, `run_en`=0. While in soft reset, all flags are cleared and strobes are ignored.
- R8: A control write with `wr_rst`=0 leaves soft reset. It sets `run_en` to `wr_run`, except when the block was in soft reset at that write and `wr_run`=1: then `run_en` stays 0 and `seq_err` is set.
- R9: A control write with both `wr_rst`=1 and `wr_run`=1 is illegal. It acts as a reset-only write and sets `seq_err`. Each control write loads `seq_err` afresh, so the next legal write clears it.
- R10: `wr_mode` selects the mode: 2'b00 video refresh, 2'b10 message, 2'b01 or 2'b11 data streaming. In message mode, a buffer-1 empty strobe while `run_en`=1 clears `run_en` in the next cycle. A control write in the same cycle takes precedence. In the other modes, `run_en` changes only by control writes.
- R11: When `run_en`=0 and the block is not in soft reset, strobes still set flags and `irq` still follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_rst | input | 1 | Control write: soft reset request |
| wr_run | input | 1 | Control write: run enable request |
| wr_mode | input | 2 | Control write: operating mode |
| wr_irq_en | input | 5 | Control write: per-flag interrupt enables |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_bits | input | 5 | Write-one-to-clear flag mask |
| ev_buf1_empty | input | 1 | Buffer one drained strobe |
| ev_buf2_empty | input | 1 | Buffer two drained strobe |
| ev_hblank | input | 1 | Horizontal blanking strobe |
| ev_field_end | input | 1 | End of field / buffer strobe, sets field threshold |
| ev_active_start | input | 1 | Next field's active area begins |
| flags | output | 5 | Sticky status flags |
| irq | output | 1 | Level interrupt |
| run_en | output | 1 | Engine run enable |
| soft_rst | output | 1 | Engine held in soft reset |
| seq_err | output | 1 | Last control write broke the start sequence |
| ptr_stale | output | 1 | Pulse: engine keeps its previous pointers |

## Verification
The bench builds each of the 32 flag patterns through the strobes, with the underrun bit produced by the real missed-acknowledge path. Against each pattern it sweeps all 32 enable masks, so an OR taken over unmasked flags or a swapped enable bit shows up as a wrong `irq`. Directed cases put a strobe and its acknowledge in the same cycle: a design that gives the acknowledge priority loses the flag. Other cases place the field acknowledge before, on, and after the active-start strobe. A design with the wrong priority either misses the underrun or reports a false one. The start sequence is tried out of order, with reset and run in one write, and in each mode. A controller that lets run rise straight out of reset, or never self-clears in message mode, ends with the wrong `run_en`.

// File: rtl/vhi_pkg.sv
`timescale 1ns/1ps
package vhi_pkg;
  localparam int NFLAG   = 5;
  localparam int MODE_W  = 2;
  localparam int FL_BUF1 = 0;
  localparam int FL_BUF2 = 1;
  localparam int FL_HBLK = 2;
  localparam int FL_UNDR = 3;
  localparam int FL_FTHR = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_VIDEO = 2'b00,
    MODE_STRM  = 2'b01,
    MODE_MSG   = 2'b10,
    MODE_STRM2 = 2'b11
  } vhi_mode_e;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/vhi_flag_cell.sv
`timescale 1ns/1ps
module vhi_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic set,
  input  logic ack,
  output logic q
);
  logic d;
  logic ce;

  always_comb begin
    ce = clr_all | set | ack;
    if (clr_all) d = 1'b0;
    else         d = (q & ~ack) | set;   // set beats acknowledge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (ce) q <= d;
  end
endmodule

// File: rtl/vhi_ctl.sv
`timescale 1ns/1ps
module vhi_ctl
  import vhi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_rst,
  input  logic              wr_run,
  input  logic [MODE_W-1:0] wr_mode,
  input  flag_vec_t         wr_irq_en,
  input  logic              ev_buf1_empty,
  output logic              soft_q,
  output logic              run_q,
  output logic              err_q,
  output vhi_mode_e         mode_q,
  output flag_vec_t         irqen_q
);
  logic      soft_d, run_d, err_d, ce;
  vhi_mode_e mode_d;
  flag_vec_t irqen_d;
  logic      msg_done;

  always_comb begin
    msg_done = ev_buf1_empty & run_q & ~soft_q & (mode_q == MODE_MSG);
    soft_d   = soft_q;
    run_d    = run_q;
    err_d    = err_q;
    mode_d   = mode_q;
    irqen_d  = irqen_q;
    ce       = wr_en | msg_done;
    if (wr_en) begin
      mode_d  = vhi_mode_e'(wr_mode);
      irqen_d = wr_irq_en;
      if (wr_rst) begin
        soft_d = 1'b1;
        run_d  = 1'b0;
        err_d  = wr_run;           // reset and run together: illegal
      end else begin
        soft_d = 1'b0;
        if (wr_run && soft_q) begin
          run_d = 1'b0;            // skipped the release step
          err_d = 1'b1;
        end else begin
          run_d = wr_run;
          err_d = 1'b0;
        end
      end
    end else if (msg_done) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q  <= 1'b0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= MODE_VIDEO;
      irqen_q <= '0;
    end else if (ce) begin
      soft_q  <= soft_d;
      run_q   <= run_d;
      err_q   <= err_d;
      mode_q  <= mode_d;
      irqen_q <= irqen_d;
    end
  end
endmodule

// File: rtl/vout_hshk_irq.sv
`timescale 1ns/1ps
module vout_hshk_irq
  import vhi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_rst,
  input  logic              wr_run,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [NFLAG-1:0]  wr_irq_en,
  input  logic              ack_we,
  input  logic [NFLAG-1:0]  ack_bits,
  input  logic              ev_buf1_empty,
  input  logic              ev_buf2_empty,
  input  logic              ev_hblank,
  input  logic              ev_field_end,
  input  logic              ev_active_start,
  output logic [NFLAG-1:0]  flags,
  output logic              irq,
  output logic              run_en,
  output logic              soft_rst,
  output logic              seq_err,
  output logic              ptr_stale
);
  logic      soft_q, run_q, err_q;
  vhi_mode_e mode_q;
  flag_vec_t irqen_q;
  flag_vec_t set_vec, ack_vec, flag_q;
  logic      undr_set;
  logic      stale_d, stale_q;

  vhi_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_rst        (wr_rst),
    .wr_run        (wr_run),
    .wr_mode       (wr_mode),
    .wr_irq_en     (wr_irq_en),
    .ev_buf1_empty (ev_buf1_empty),
    .soft_q        (soft_q),
    .run_q         (run_q),
    .err_q         (err_q),
    .mode_q        (mode_q),
    .irqen_q       (irqen_q)
  );

  always_comb begin
    ack_vec  = ack_we ? ack_bits : '0;
    // field pointers still unacknowledged when the next active area opens
    undr_set = ev_active_start & flag_q[FL_FTHR] & ~ack_vec[FL_FTHR];
    set_vec           = '0;
    set_vec[FL_BUF1]  = ev_buf1_empty;
    set_vec[FL_BUF2]  = ev_buf2_empty;
    set_vec[FL_HBLK]  = ev_hblank;
    set_vec[FL_UNDR]  = undr_set;
    set_vec[FL_FTHR]  = ev_field_end;
    stale_d  = undr_set & ~soft_q;
  end

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    vhi_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (soft_q),
      .set     (set_vec[gi]),
      .ack     (ack_vec[gi]),
      .q       (flag_q[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stale_q <= 1'b0;
    else        stale_q <= stale_d;
  end

  assign flags     = flag_q;
  assign irq       = |(flag_q & irqen_q);
  assign run_en    = run_q;
  assign soft_rst  = soft_q;
  assign seq_err   = err_q;
  assign ptr_stale = stale_q;
endmodule

// File: rtl/vhi_chk.sv
`timescale 1ns/1ps
module vhi_chk
  import vhi_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_rst,
  input logic             wr_run,
  input logic             ack_we,
  input logic [NFLAG-1:0] ack_bits,
  input logic             ev_buf1_empty,
  input logic             ev_field_end,
  input logic             ev_active_start,
  input logic [NFLAG-1:0] flags,
  input logic             irq,
  input logic             run_en,
  input logic             soft_rst,
  input logic             seq_err,
  input logic             ptr_stale,
  input vhi_mode_e        mode_q
);
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_bits[FL_FTHR] && !ev_field_end) |=> !flags[FL_FTHR]); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_field_end && !soft_rst) |=> flags[FL_FTHR]); // R4

  AST_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_active_start && flags[FL_FTHR] && !(ack_we && ack_bits[FL_FTHR]) && !soft_rst)
    |=> (flags[FL_UNDR] && ptr_stale)); // R5

  AST_STALE_NEEDS_UNDR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_stale |-> flags[FL_UNDR]); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq); // R6

  AST_NO_RUN_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !run_en); // R7

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == '0)); // R7

  AST_ILLEGAL_AS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_rst && wr_run) |=> (soft_rst && !run_en && seq_err)); // R9

  AST_MSG_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf1_empty && run_en && mode_q == MODE_MSG && !wr_en) |=> !run_en); // R10
endmodule

bind vout_hshk_irq vhi_chk u_vhi_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_en           (wr_en),
  .wr_rst          (wr_rst),
  .wr_run          (wr_run),
  .ack_we          (ack_we),
  .ack_bits        (ack_bits),
  .ev_buf1_empty   (ev_buf1_empty),
  .ev_field_end    (ev_field_end),
  .ev_active_start (ev_active_start),
  .flags           (flags),
  .irq             (irq),
  .run_en          (run_en),
  .soft_rst        (soft_rst),
  .seq_err         (seq_err),
  .ptr_stale       (ptr_stale),
  .mode_q          (mode_q)
);

// File: tb/test_vout_hshk_irq.sv
`timescale 1ns/1ps
module test_vout_hshk_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_rst, wr_run;
  logic [1:0] wr_mode;
  logic [4:0] wr_irq_en;
  logic       ack_we;
  logic [4:0] ack_bits;
  logic       ev_b1, ev_b2, ev_hb, ev_fe, ev_as;
  logic [4:0] flags;
  logic       irq, run_en, soft_rst, seq_err, ptr_stale;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vout_hshk_irq i_vout_hshk_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_rst(wr_rst), .wr_run(wr_run), .wr_mode(wr_mode),
    .wr_irq_en(wr_irq_en), .ack_we(ack_we), .ack_bits(ack_bits),
    .ev_buf1_empty(ev_b1), .ev_buf2_empty(ev_b2), .ev_hblank(ev_hb),
    .ev_field_end(ev_fe), .ev_active_start(ev_as),
    .flags(flags), .irq(irq), .run_en(run_en), .soft_rst(soft_rst),
    .seq_err(seq_err), .ptr_stale(ptr_stale)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_rst = 0; wr_run = 0;
    ack_we = 0; ack_bits = '0;
    ev_b1 = 0; ev_b2 = 0; ev_hb = 0; ev_fe = 0; ev_as = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic ctl(input logic r, input logic e, input logic [1:0] m, input logic [4:0] ie);
    wr_en = 1; wr_rst = r; wr_run = e; wr_mode = m; wr_irq_en = ie;
    tick();
  endtask

  task automatic ack(input logic [4:0] b);
    ack_we = 1; ack_bits = b;
    tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    idle(); wr_mode = 2'b00; wr_irq_en = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 run_en", run_en, 0);
    chk("R1 soft_rst", soft_rst, 0);
    chk("R1 seq_err", seq_err, 0);
    chk("R1 ptr_stale", ptr_stale, 0);

    // R2 R5 R6 sweep: every flag pattern against every enable mask
    for (int fl = 0; fl < 32; fl++) begin
      ack(5'h1f);
      if (fl[3]) begin
        ev_fe = 1; tick();
        ev_as = 1; tick();
      end
      ev_b1 = fl[0]; ev_b2 = fl[1]; ev_hb = fl[2]; ev_fe = fl[4];
      ack_we = 1; ack_bits = {fl[3] & ~fl[4], 4'b0000};
      tick();
      chk("R2 flag pattern", flags, fl);
      for (int en = 0; en < 32; en++) begin
        ctl(0, 0, 2'b00, en[4:0]);
        chk("R6 irq mask", irq, |(fl[4:0] & en[4:0]));
      end
    end

    // R3 zero bits do nothing, single bit clears only itself
    ctl(0, 0, 2'b00, 5'h00);
    for (int i = 0; i < 5; i++) begin
      ack(5'h1f);
      ev_fe = 1; tick(); ev_as = 1; tick();
      ev_b1 = 1; ev_b2 = 1; ev_hb = 1; tick();
      ack(5'h00);
      chk("R3 zero ack", flags, 5'h1f);
      ack(5'h01 << i);
      chk("R3 single ack", flags, 5'h1f & ~(5'h01 << i));
    end

    // R4 strobe beats same-cycle acknowledge
    ack(5'h1f);
    ev_b1 = 1; ev_b2 = 1; ev_hb = 1; ev_fe = 1; tick();
    ev_b1 = 1; ev_b2 = 1; ev_hb = 1; ev_fe = 1;
    ack_we = 1; ack_bits = 5'h1f; tick();
    chk("R4 event wins", flags, 5'h17);

    // R5 missed deadline
    ack(5'h1f);
    ev_fe = 1; tick();
    ev_as = 1; tick();
    chk("R5 underrun set", flags, 5'h18);
    chk("R5 stale pulse", ptr_stale, 1);
    tick();
    chk("R5 stale one cycle", ptr_stale, 0);
    // acknowledged in time
    ack(5'h1f);
    ev_fe = 1; tick();
    ack(5'h10);
    ev_as = 1; tick();
    chk("R5 early ack no underrun", flags, 0);
    chk("R5 early ack no stale", ptr_stale, 0);
    // acknowledged in the same cycle
    ev_fe = 1; tick();
    ev_as = 1; ack_we = 1; ack_bits = 5'h10; tick();
    chk("R5 same-cycle ack no underrun", flags, 0);
    chk("R5 same-cycle ack no stale", ptr_stale, 0);

    // R11 flags and irq while stopped, not in reset
    ctl(0, 0, 2'b00, 5'h04);
    ev_hb = 1; tick();
    chk("R11 flag while stopped", flags, 5'h04);
    chk("R11 irq while stopped", irq, 1);

    // R7 soft reset clears and holds flags
    ctl(1, 0, 2'b00, 5'h1f);
    chk("R7 soft_rst", soft_rst, 1);
    chk("R7 run_en", run_en, 0);
    tick();
    chk("R7 flags cleared", flags, 0);
    ev_b1 = 1; ev_b2 = 1; ev_hb = 1; ev_fe = 1; tick();
    chk("R7 strobes ignored", flags, 0);
    chk("R7 irq quiet", irq, 0);

    // R8 run straight out of reset is refused
    ctl(0, 1, 2'b00, 5'h00);
    chk("R8 run refused", run_en, 0);
    chk("R8 seq_err", seq_err, 1);
    chk("R8 reset released", soft_rst, 0);
    // proper sequence
    ctl(1, 0, 2'b00, 5'h00);
    ctl(0, 0, 2'b00, 5'h00);
    chk("R8 release no err", seq_err, 0);
    ctl(0, 1, 2'b00, 5'h00);
    chk("R8 run set", run_en, 1);
    chk("R8 run no err", seq_err, 0);

    // R9 reset and run together
    ctl(1, 1, 2'b00, 5'h00);
    chk("R9 acts as reset", soft_rst, 1);
    chk("R9 no run", run_en, 0);
    chk("R9 seq_err", seq_err, 1);
    ctl(0, 0, 2'b00, 5'h00);
    chk("R9 err cleared", seq_err, 0);

    // R10 message mode self-clear, other modes hold
    ctl(0, 1, 2'b10, 5'h00);
    chk("R10 msg running", run_en, 1);
    ev_b1 = 1; tick();
    chk("R10 msg self-clear", run_en, 0);
    chk("R10 msg flag", flags[0], 1);
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      ctl(0, 1, m[1:0], 5'h00);
      ev_b1 = 1; tick();
      chk("R10 non-msg holds", run_en, 1);
    end
    // write in same cycle takes precedence
    ctl(0, 1, 2'b10, 5'h00);
    ev_b1 = 1; wr_en = 1; wr_rst = 0; wr_run = 1; wr_mode = 2'b10; tick();
    chk("R10 write precedence", run_en, 1);

    done = 1'b1;
    summary();
  end
endmodule